// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a memory-mapped countdown timer that sits beside a processor core and raises an interrupt request when its count runs out. Software programs four things through a 32-bit register port: a clock divide ratio, a timer entry (vector, mask and mode), a start value, and an end-of-interrupt strobe. It can also read the running count at any time. A prescaler divides the bus clock by a power of two from 1 to 128, and each prescaler tick takes one off the count.

When the count expires, the block raises `irqReq` carrying the programmed 8-bit vector. It holds the request until the consumer accepts it with `irqAck`. An accepted request puts the block in service, and it raises no further request until software writes the end-of-interrupt register. In periodic mode the count reloads from the start value and keeps going. In one-shot mode it halts at zero.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset `irqReq` is 0. The timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The divide, start-count and current-count registers read 0.
- R2: The divide register's 4-bit code selects the tick ratio. The codes are 0x0 for 2, 0x1 for 4, 0x2 for 8, 0x3 for 16, 0x8 for 32, 0x9 for 64, 0xA for 128 and 0xB for 1. After a start-count write of N at a clock edge, the expiry happens exactly N×ratio edges later.
- R3: Bit 2 of the divide code (byte address 0x3E0) always reads 0, whatever was written. Bits 31:4 of that register read 0.
- R4: Writing the start-count register (0x380) loads the count and restarts the prescaler. The current-count register (0x390) reads the live count, which falls by one for every ratio edges.
- R5: In one-shot mode (timer entry bit 17 = 0), expiry leaves the current count at 0, and no further request follows.
- R6: In periodic mode (bit 17 = 1), expiry reloads the start value, and the next expiry follows N×ratio edges later.
- R7: A start count of 0 stops the timer: the current count reads 0 and no request is raised.
- R8: While the mask bit (bit 16) is 1, expiry raises no request and does not set the delivery status, but the count keeps running and reloading.
- R9: An unmasked expiry raises `irqReq` with `irqVector` equal to timer entry bits 7:0. The delivery status (bit 12) reads 1 from the expiry until `irqReq` and `irqAck` are both high at a clock edge, then reads 0.
- R10: An accepted request puts the block in service. While in service, `irqReq` stays 0 even if a new expiry is pending. A write to the end-of-interrupt register (0x0B0) ends the service state.
- R11: Timer entry (0x320) bits other than 17, 16, 12 and 7:0 read 0, and bit 12 ignores writes. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one write per cycle |
| regAddr | input | 12 | Byte address for both write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irqReq | output | 1 | Interrupt request |
| irqVector | output | 8 | Vector carried with the request |
| irqAck | input | 1 | Consumer accepts the request when high with `irqReq` |

## Verification
The bench goes after the divide encoding. The codes are non-contiguous, so a decoder that treats the field as a plain binary shift gives the wrong ratio for the upper four codes. Expiry timing is pinned to a single edge, so an off-by-one in the reload or in the prescaler phase moves the request a cycle early or late. The bench also covers four behaviours that are easy to get wrong:
- Under a mask, a design that also stops the count shows a frozen current count.
- A design that lets a pending expiry through while in service raises a request before the end-of-interrupt write.
- A zero start count must stay silent.
- Divide bit 2 must read back as 0.

// File: rtl/lct_pkg.sv
package lct_pkg;

  localparam int REG_ADDR_W = 12;

  localparam logic [REG_ADDR_W-1:0] OFS_EOI  = 12'h0B0;
  localparam logic [REG_ADDR_W-1:0] OFS_LVT  = 12'h320;
  localparam logic [REG_ADDR_W-1:0] OFS_INIT = 12'h380;
  localparam logic [REG_ADDR_W-1:0] OFS_CUR  = 12'h390;
  localparam logic [REG_ADDR_W-1:0] OFS_DIV  = 12'h3E0;

  localparam int LVT_STATUS_BIT = 12;
  localparam int LVT_MASK_BIT   = 16;
  localparam int LVT_MODE_BIT   = 17;
  localparam int VEC_W          = 8;
  localparam int DIV_CODE_W     = 4;
  localparam int SHIFT_W        = 3;

  typedef struct packed {
    logic               loadCount;
    logic               periodic;
    logic [SHIFT_W-1:0] divShift;
  } ctrl_strobe_t;

  // The code is non-contiguous: {b3,b1,b0} counts 0..7 for ratios 2..128,
  // and 7 wraps to a ratio of 1.
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [DIV_CODE_W-1:0] code);
    logic [SHIFT_W-1:0] idx;
    idx = {code[3], code[1], code[0]};
    return idx + SHIFT_W'(1);
  endfunction

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] divShift,
  output logic               tick
);
  localparam int PRESC_W = (1 << SHIFT_W) - 1;

  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] presMask;

  always_comb begin
    for (int i = 0; i < PRESC_W; i++) begin
      presMask[i] = (i < int'(divShift));
    end
  end

  assign tick = ((presc & presMask) == presMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
    end else if (restart) begin
      presc <= '0;
    end else if (tick) begin
      presc <= '0;
    end else begin
      presc <= presc + PRESC_W'(1);
    end
  end

  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (tick == (divShift == '0)));  // R2

endmodule

// File: rtl/lct_datapath.sv
module lct_datapath
  import lct_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  input  logic [COUNT_W-1:0] loadValue,
  output logic               expire,
  output logic [COUNT_W-1:0] curCount,
  output logic [COUNT_W-1:0] initCount
);
  logic               tick;
  logic               running;
  logic [COUNT_W-1:0] count;
  logic [COUNT_W-1:0] initReg;
  logic               atLast;

  lct_prescaler #(.SHIFT_W(SHIFT_W)) u_prescaler (
    .clk      (clk),
    .rstN     (rstN),
    .restart  (strobe.loadCount),
    .divShift (strobe.divShift),
    .tick     (tick)
  );

  assign atLast = (count == COUNT_W'(1));
  assign expire = tick && running && atLast && !strobe.loadCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      count   <= '0;
      initReg <= '0;
    end else if (strobe.loadCount) begin
      initReg <= loadValue;
      count   <= loadValue;
      running <= (loadValue != '0);
    end else if (tick && running) begin
      if (atLast) begin
        if (strobe.periodic) begin
          count <= initReg;
        end else begin
          count   <= '0;
          running <= 1'b0;
        end
      end else begin
        count <= count - COUNT_W'(1);
      end
    end
  end

  assign curCount  = count;
  assign initCount = initReg;

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !strobe.periodic) |=> (curCount == '0));  // R5

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (expire && strobe.periodic) |=> (curCount == initCount));  // R6

  AST_ZERO_START_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCount && loadValue == '0) |=> (curCount == '0 && !expire));  // R7

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobe.loadCount) |=> $stable(count));  // R4

endmodule

// File: rtl/lct_ctrl.sv
module lct_ctrl
  import lct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector,
  input  logic              expireIn,
  input  logic [DATA_W-1:0] curCount,
  input  logic [DATA_W-1:0] initCount,
  output ctrl_strobe_t      strobe,
  output logic [DATA_W-1:0] loadValue
);
  logic [VEC_W-1:0]      lvtVector;
  logic                  lvtMask;
  logic                  lvtPeriodic;
  logic [DIV_CODE_W-1:0] divCode;
  logic                  pending;
  logic                  inService;
  logic                  wrLvt, wrInit, wrDiv, wrEoi;
  logic                  accept;

  assign wrLvt  = regWrEn && (regAddr == ADDR_W'(OFS_LVT));
  assign wrInit = regWrEn && (regAddr == ADDR_W'(OFS_INIT));
  assign wrDiv  = regWrEn && (regAddr == ADDR_W'(OFS_DIV));
  assign wrEoi  = regWrEn && (regAddr == ADDR_W'(OFS_EOI));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvtVector   <= '0;
      lvtMask     <= 1'b1;
      lvtPeriodic <= 1'b0;
      divCode     <= '0;
    end else begin
      if (wrLvt) begin
        lvtVector   <= regWrData[VEC_W-1:0];
        lvtMask     <= regWrData[LVT_MASK_BIT];
        lvtPeriodic <= regWrData[LVT_MODE_BIT];
      end
      if (wrDiv) begin
        divCode <= {regWrData[3], 1'b0, regWrData[1:0]};
      end
    end
  end

  assign irqReq    = pending && !inService;
  assign irqVector = lvtVector;
  assign accept    = irqReq && irqAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      inService <= 1'b0;
    end else begin
      if (expireIn && !lvtMask) begin
        pending <= 1'b1;
      end else if (accept) begin
        pending <= 1'b0;
      end
      if (accept) begin
        inService <= 1'b1;
      end else if (wrEoi) begin
        inService <= 1'b0;
      end
    end
  end

  assign strobe.loadCount = wrInit;
  assign strobe.periodic  = lvtPeriodic;
  assign strobe.divShift  = code_to_shift(divCode);
  assign loadValue        = regWrData;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(OFS_LVT)) begin
      regRdData[VEC_W-1:0]     = lvtVector;
      regRdData[LVT_STATUS_BIT] = pending;
      regRdData[LVT_MASK_BIT]   = lvtMask;
      regRdData[LVT_MODE_BIT]   = lvtPeriodic;
    end else if (regAddr == ADDR_W'(OFS_INIT)) begin
      regRdData = initCount;
    end else if (regAddr == ADDR_W'(OFS_CUR)) begin
      regRdData = curCount;
    end else if (regAddr == ADDR_W'(OFS_DIV)) begin
      regRdData[DIV_CODE_W-1:0] = divCode;
    end
  end

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (lvtMask && !pending) |=> !pending);  // R8

  AST_ACK_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !expireIn) |=> !pending);  // R9

  AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (inService && !irqReq));  // R10

  AST_EOI_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEoi && !accept) |=> !inService);  // R10

  AST_DIV_BIT2_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !divCode[2]);  // R3

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import lct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector,
  input  logic              irqAck
);
  ctrl_strobe_t      strobe;
  logic [DATA_W-1:0] loadValue;
  logic              expire;
  logic [DATA_W-1:0] curCount;
  logic [DATA_W-1:0] initCount;

  lct_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqAck    (irqAck),
    .irqReq    (irqReq),
    .irqVector (irqVector),
    .expireIn  (expire),
    .curCount  (curCount),
    .initCount (initCount),
    .strobe    (strobe),
    .loadValue (loadValue)
  );

  lct_datapath #(.COUNT_W(DATA_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadValue (loadValue),
    .expire    (expire),
    .curCount  (curCount),
    .initCount (initCount)
  );

endmodule

// File: tb/irq_countdown_timer_bench.sv
`timescale 1ns/1ps
module irq_countdown_timer_bench;
  localparam logic [11:0] A_EOI  = 12'h0B0;
  localparam logic [11:0] A_LVT  = 12'h320;
  localparam logic [11:0] A_INIT = 12'h380;
  localparam logic [11:0] A_CUR  = 12'h390;
  localparam logic [11:0] A_DIV  = 12'h3E0;

  // {divide code, start count, vector}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {4'h0, 8'd3, 8'h21}, {4'h1, 8'd2, 8'h32}, {4'h2, 8'd3, 8'h43},
    {4'h3, 8'd2, 8'h54}, {4'h8, 8'd2, 8'h65}, {4'h9, 8'd1, 8'h76},
    {4'hA, 8'd2, 8'h87}, {4'hB, 8'd7, 8'h98}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqReq;
  logic [7:0]  irqVector;
  logic        irqAck = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  irq_countdown_timer u_irq_countdown_timer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqReq(irqReq),
    .irqVector(irqVector), .irqAck(irqAck)
  );

  function automatic int divRatio(input logic [3:0] code);
    case (code)
      4'h0: return 2;   4'h1: return 4;   4'h2: return 8;   4'h3: return 16;
      4'h8: return 32;  4'h9: return 64;  4'hA: return 128; 4'hB: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Caller is at a negedge; the write lands on the next posedge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a; #0.5; d = regRdData;
  endtask

  task automatic ack();
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    edges(3);
    rstN = 1'b1;
    edges(1);

    // R1 reset state
    chk("R1 irqReq", {31'b0, irqReq}, 32'h0);
    rd(A_LVT, rv);  chk("R1 lvt", rv, 32'h0001_0000);
    rd(A_DIV, rv);  chk("R1 div", rv, 32'h0);
    rd(A_INIT, rv); chk("R1 init", rv, 32'h0);
    rd(A_CUR, rv);  chk("R1 cur", rv, 32'h0);

    // R3 divide bit 2 and reserved bits
    wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, rv); chk("R3 div all ones", rv, 32'hB);
    wr(A_DIV, 32'h0000_0004); rd(A_DIV, rv); chk("R3 div bit2 only", rv, 32'h0);

    // R11 timer entry reserved bits and unmapped address
    wr(A_LVT, 32'hFFFF_FFFF); rd(A_LVT, rv); chk("R11 lvt readback", rv, 32'h0003_00FF);
    rd(12'h100, rv); chk("R11 unmapped", rv, 32'h0);

    // R2 / R9 table of divide codes, one-shot, unmasked
    for (int i = 0; i < NV; i++) begin
      logic [3:0] code;
      int n, t;
      logic [7:0] v;
      code = VEC[i][19:16]; n = int'(VEC[i][15:8]); v = VEC[i][7:0];
      t = n * divRatio(code);
      wr(A_DIV, {28'b0, code});
      wr(A_LVT, {24'b0, v});
      wr(A_INIT, n);
      edges(t - 1);
      chk("R2 no early expiry", {31'b0, irqReq}, 32'h0);
      edges(1);
      chk("R2 expiry on time", {31'b0, irqReq}, 32'h1);
      chk("R9 vector", {24'b0, irqVector}, {24'b0, v});
      rd(A_LVT, rv); chk("R9 status set", {31'b0, rv[12]}, 32'h1);
      ack();
      rd(A_LVT, rv); chk("R9 status cleared", {31'b0, rv[12]}, 32'h0);
      wr(A_EOI, 32'h0);
    end

    // R4 live count
    wr(A_DIV, 32'hB); wr(A_INIT, 32'd100); edges(10);
    rd(A_CUR, rv); chk("R4 cur div1", rv, 32'd90);
    wr(A_DIV, 32'h0); wr(A_INIT, 32'd100); edges(10);
    rd(A_CUR, rv); chk("R4 cur div2", rv, 32'd95);
    rd(A_INIT, rv); chk("R4 init readback", rv, 32'd100);

    // R5 one-shot halts at zero
    wr(A_DIV, 32'hB); wr(A_LVT, 32'h0000_0011); wr(A_INIT, 32'd4);
    edges(4);
    chk("R5 expiry", {31'b0, irqReq}, 32'h1);
    rd(A_CUR, rv); chk("R5 cur zero", rv, 32'h0);
    ack(); wr(A_EOI, 32'h0); edges(20);
    chk("R5 no repeat", {31'b0, irqReq}, 32'h0);
    rd(A_CUR, rv); chk("R5 cur stays zero", rv, 32'h0);

    // R6 periodic reload
    wr(A_LVT, 32'h0002_0040); wr(A_INIT, 32'd5);
    edges(5);
    chk("R6 first expiry", {31'b0, irqReq}, 32'h1);
    ack(); wr(A_EOI, 32'h0);
    edges(2);
    chk("R6 not early", {31'b0, irqReq}, 32'h0);
    edges(1);
    chk("R6 second expiry", {31'b0, irqReq}, 32'h1);
    rd(A_CUR, rv); chk("R6 reloaded", rv, 32'd5);
    ack(); wr(A_INIT, 32'd0); wr(A_EOI, 32'h0);

    // R7 zero start count
    edges(30);
    chk("R7 silent", {31'b0, irqReq}, 32'h0);
    rd(A_CUR, rv); chk("R7 cur zero", rv, 32'h0);

    // R8 masked periodic keeps running
    wr(A_LVT, 32'h0003_0050); wr(A_INIT, 32'd4);
    edges(4);
    chk("R8 no request", {31'b0, irqReq}, 32'h0);
    rd(A_CUR, rv); chk("R8 reloaded", rv, 32'd4);
    edges(1);
    rd(A_CUR, rv); chk("R8 still counting", rv, 32'd3);
    rd(A_LVT, rv); chk("R8 status idle", {31'b0, rv[12]}, 32'h0);
    wr(A_INIT, 32'd0);

    // R10 in-service blocks a new request until EOI
    wr(A_LVT, 32'h0002_0060); wr(A_INIT, 32'd3);
    edges(3);
    chk("R10 first request", {31'b0, irqReq}, 32'h1);
    ack();
    edges(2);
    chk("R10 held in service", {31'b0, irqReq}, 32'h0);
    rd(A_LVT, rv); chk("R10 pending while in service", {31'b0, rv[12]}, 32'h1);
    wr(A_EOI, 32'h0);
    chk("R10 released by EOI", {31'b0, irqReq}, 32'h1);
    ack(); wr(A_INIT, 32'd0); wr(A_EOI, 32'h0);
    edges(10);
    chk("R10 idle after stop", {31'b0, irqReq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule